// File: doc/BRIEF.md
# Pseudo-SRAM Single-Access Controller

This block sits between a clocked host port and an asynchronous pseudo-SRAM with SRAM-style strobes. The memory has a 1M x 16 organisation. The host raises a request while the controller reports ready, and it supplies a write flag, a word address, write data and two byte-lane enables. The controller captures the request and drives a chip select, a write strobe, a read strobe, two byte-lane selects and a data bus with a separate drive enable. It returns read data together with a one-clock valid pulse.

Every phase of an access lasts a whole number of clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period parameter.

- A read holds the strobes for the access time, then keeps the chip deselected for the recovery time.
- A write holds the strobes for the write pulse, then keeps the chip deselected for the recovery time.
- In both cases the recovery is long enough that the deselect gap is met and the random-cycle window is filled.

The second chip enable is held active, so the memory never enters its power-down state. Only single reads and single writes are performed.

Top module: `psram_ctrl`

## Requirements
- R1: During and after reset, with no access in progress: `mem_cs_n`, `mem_wr_n`, `mem_rd_n`, `mem_blo_n` and `mem_bhi_n` are high, `mem_pwr_en` is high, `mem_d_drive` is low, `host_ready` is high and `host_rvalid` is low.
- R2: A read holds `mem_cs_n` low and `mem_rd_n` low for exactly ceil(T_CE_NS/CLK_PERIOD_NS) cycles, and during that time `mem_wr_n` is high and both lane selects are low. The word is captured at the end of that window. It appears on `host_rdata` while `host_rvalid` is high, and `host_rvalid` is high for exactly one cycle per read.
- R3: A write holds `mem_cs_n` and `mem_wr_n` low together for max(ceil(T_WP_NS/T), ceil(T_DS_NS/T)) cycles, where T is CLK_PERIOD_NS. `mem_rd_n` is high when the chip select falls and stays high for the whole write. `host_be[0]` selects bits 7:0 (drives `mem_blo_n` low) and `host_be[1]` selects bits 15:8 (drives `mem_bhi_n` low). With `host_be` = 00 no bit of the memory changes.
- R4: Write data is driven for the whole write strobe and for one cycle after the strobe rises, then released. `mem_d_drive` is never high while `mem_rd_n` is low.
- R5: Between two accesses `mem_cs_n` stays high for at least T_CP_NS. Two successive chip-select falls are at least T_RC_NS (read) or T_WC_NS (write) apart.
- R6: `host_ready` is low for exactly 1 + L + Q cycles from the accepting edge, where L and Q depend on the access.
  - For a read, L is the R2 strobe length and Q is max(ceil(T_CP_NS/T), ceil(T_RC_NS/T) - L).
  - For a write, L is the R3 strobe length and Q is max(ceil(T_WR_NS/T), ceil(T_CP_NS/T), ceil(T_WC_NS/T) - L).
- R7: `mem_addr` carries the accepted address and does not change while `mem_cs_n` is low.
- R8: A request raised while `host_ready` is low is ignored. It neither starts an access nor alters memory contents.
- R9: `mem_rd_n` is never low for more than 1000 ns at a stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Access request, taken when `host_ready` is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte-lane enables for writes, bit 0 = bits 7:0 |
| host_ready | output | 1 | High when a request can be accepted |
| host_rdata | output | 16 | Captured read word |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_pwr_en | output | 1 | Second enable, active high, held high |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Output enable of the memory, active low |
| mem_blo_n | output | 1 | Lane select for bits 7:0, active low |
| mem_bhi_n | output | 1 | Lane select for bits 15:8, active low |
| mem_d_out | output | 16 | Data toward the memory |
| mem_d_drive | output | 1 | Enable for the data-bus drivers |
| mem_d_in | input | 16 | Data from the memory |

## Verification
The bench builds the controller with ADDR_W = 4 and CLK_PERIOD_NS = 4, so every one of the sixteen words is written, read and byte-patched in full sweeps.

At that period the default timings round to:

| Count | Cycles |
|---|---|
| Read strobe | 20 |
| Write strobe | 15 |
| Read recovery (bound by the deselect gap) | 5 |
| Write recovery (bound by the cycle window) | 8 |

This means both branches of the recovery maximum are exercised. The memory model drives a poison word outside a valid read, so data captured at the wrong moment shows up as a data mismatch.

// File: rtl/psram_pkg.sv
// Shared constants, phase encoding and cycle-count helpers for the
// pseudo-SRAM controller. Assumes every timing value is given in whole ns.
package psram_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_READ,
        PH_WRITE,
        PH_RECOVER
    } phase_e;

    // Ceiling of ns / period, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b floored at zero.
    function automatic int unsigned sub_sat(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/psram_phase_timer.sv
// Down-counter that times one controller phase.
// Loading N-1 on phase entry makes done rise in the phase's Nth cycle.
// Assumes load is asserted only on the cycle before a phase change.
module psram_phase_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Reload on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_seq.sv
// Phase sequencer: idle -> setup -> read or write strobe -> recovery -> idle.
// Lengths are in cycles and must be at least one.
// The next-phase value is exported so that the pin stage can register strobes without glitches.
module psram_seq
    import psram_pkg::*;
#(
    parameter int unsigned CW       = 5,
    parameter int unsigned LEN_RD   = 20,
    parameter int unsigned LEN_WR   = 15,
    parameter int unsigned LEN_RREC = 5,
    parameter int unsigned LEN_WREC = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_req,
    input  logic          host_we,
    input  logic          tmr_done,
    output phase_e        phase_q,
    output phase_e        phase_d,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          accept,
    output logic          host_ready
);

    logic op_wr_q;

    assign host_ready = (phase_q == PH_IDLE);
    assign accept     = host_ready && host_req;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Remember whether the accepted access is a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_wr_q <= 1'b0;
        end else if (accept) begin
            op_wr_q <= host_we;
        end
    end

    // Next-phase decision; strobe and recovery phases end on the timer.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:    if (host_req)  phase_d = PH_SETUP;
            PH_SETUP:   if (tmr_done)  phase_d = op_wr_q ? PH_WRITE : PH_READ;
            PH_READ:    if (tmr_done)  phase_d = PH_RECOVER;
            PH_WRITE:   if (tmr_done)  phase_d = PH_RECOVER;
            PH_RECOVER: if (tmr_done)  phase_d = PH_IDLE;
            default:                   phase_d = PH_IDLE;
        endcase
    end

    // Timer reload value for the phase being entered.
    always_comb begin
        tmr_load = (phase_d != phase_q);
        case (phase_d)
            PH_READ:    tmr_val = CW'(LEN_RD - 1);
            PH_WRITE:   tmr_val = CW'(LEN_WR - 1);
            PH_RECOVER: tmr_val = op_wr_q ? CW'(LEN_WREC - 1) : CW'(LEN_RREC - 1);
            default:    tmr_val = '0;
        endcase
    end

endmodule

// File: rtl/psram_pin_drive.sv
// Registered memory-side pins and host read capture.
// Strobes are decoded from the next phase, so each pin changes exactly on the edge that enters a phase.
// The data drive lasts one cycle past the write strobe so that data hold time is met.
// Assumes the request fields are valid in the accepting cycle.
module psram_pin_drive
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]   host_wdata,
    input  logic [LANES-1:0]    host_be,
    input  phase_e              phase_q,
    input  phase_e              phase_d,
    input  logic [DATA_W-1:0]   mem_d_in,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_cs_n,
    output logic                mem_wr_n,
    output logic                mem_rd_n,
    output logic [LANES-1:0]    lane_n,
    output logic [DATA_W-1:0]   mem_d_out,
    output logic                mem_d_drive,
    output logic [DATA_W-1:0]   host_rdata,
    output logic                host_rvalid
);

    logic [LANES-1:0] be_q;
    logic [LANES-1:0] lane_d;
    logic             enter_rd;
    logic             enter_wr;
    logic             rd_end;

    assign enter_rd = (phase_d == PH_READ);
    assign enter_wr = (phase_d == PH_WRITE);
    assign rd_end   = (phase_q == PH_READ) && (phase_d != PH_READ);

    // Capture the request fields; they are held until the next acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_d_out <= '0;
            be_q      <= '0;
        end else if (accept) begin
            mem_addr  <= host_addr;
            mem_d_out <= host_wdata;
            be_q      <= host_be;
        end
    end

    // Per-lane select: every lane on reads, the enabled lanes on writes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_d[g] = !(enter_rd || (enter_wr && be_q[g]));
    end

    // Register the strobes from the phase being entered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n    <= 1'b1;
            mem_wr_n    <= 1'b1;
            mem_rd_n    <= 1'b1;
            lane_n      <= '1;
            mem_d_drive <= 1'b0;
        end else begin
            mem_cs_n    <= !(enter_rd || enter_wr);
            mem_wr_n    <= !enter_wr;
            mem_rd_n    <= !enter_rd;
            lane_n      <= lane_d;
            mem_d_drive <= enter_wr || (phase_q == PH_WRITE);
        end
    end

    // Sample the memory word at the close of the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_end;
            if (rd_end) begin
                host_rdata <= mem_d_in;
            end
        end
    end

endmodule

// File: rtl/psram_ctrl.sv
// Pseudo-SRAM single-access controller top.
// Turns one host request into an asynchronous SRAM-style read or write.
// All nanosecond timings are rounded up to whole cycles of CLK_PERIOD_NS.
// Assumes the memory's second enable may stay high permanently.
module psram_ctrl
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_CE_NS       = 80,
    parameter int unsigned T_RC_NS       = 90,
    parameter int unsigned T_WP_NS       = 60,
    parameter int unsigned T_WR_NS       = 15,
    parameter int unsigned T_WC_NS       = 90,
    parameter int unsigned T_CP_NS       = 20,
    parameter int unsigned T_DS_NS       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    input  logic [1:0]        host_be,
    output logic              host_ready,
    output logic [15:0]       host_rdata,
    output logic              host_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_pwr_en,
    output logic              mem_wr_n,
    output logic              mem_rd_n,
    output logic              mem_blo_n,
    output logic              mem_bhi_n,
    output logic [15:0]       mem_d_out,
    output logic              mem_d_drive,
    input  logic [15:0]       mem_d_in
);

    localparam int unsigned N_CE     = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RC     = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP     = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WR     = ns_to_cyc(T_WR_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WC     = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_CP     = ns_to_cyc(T_CP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_DS     = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
    localparam int unsigned LEN_RD   = N_CE;
    localparam int unsigned LEN_WR   = umax(N_WP, N_DS);
    localparam int unsigned LEN_RREC = umax(N_CP, sub_sat(N_RC, LEN_RD));
    localparam int unsigned LEN_WREC = umax(umax(N_WR, N_CP), sub_sat(N_WC, LEN_WR));
    localparam int unsigned LEN_MAX  = umax(umax(LEN_RD, LEN_WR), umax(LEN_RREC, LEN_WREC));
    localparam int unsigned CW       = $clog2(LEN_MAX + 1);

    phase_e            phase_q;
    phase_e            phase_d;
    logic              tmr_load;
    logic [CW-1:0]     tmr_val;
    logic              tmr_done;
    logic              accept;
    logic [LANES-1:0]  lane_n;

    assign mem_pwr_en = 1'b1;
    assign mem_blo_n  = lane_n[0];
    assign mem_bhi_n  = lane_n[1];

    psram_phase_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_seq #(
        .CW       (CW),
        .LEN_RD   (LEN_RD),
        .LEN_WR   (LEN_WR),
        .LEN_RREC (LEN_RREC),
        .LEN_WREC (LEN_WREC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_we    (host_we),
        .tmr_done   (tmr_done),
        .phase_q    (phase_q),
        .phase_d    (phase_d),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .accept     (accept),
        .host_ready (host_ready)
    );

    psram_pin_drive #(
        .ADDR_W (ADDR_W)
    ) u_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_be     (host_be),
        .phase_q     (phase_q),
        .phase_d     (phase_d),
        .mem_d_in    (mem_d_in),
        .mem_addr    (mem_addr),
        .mem_cs_n    (mem_cs_n),
        .mem_wr_n    (mem_wr_n),
        .mem_rd_n    (mem_rd_n),
        .lane_n      (lane_n),
        .mem_d_out   (mem_d_out),
        .mem_d_drive (mem_d_drive),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

endmodule

// File: rtl/psram_ctrl_checks.sv
// Port-level protocol checks for psram_ctrl.
// Pulse widths and gaps are measured with saturating counters instead of long $past chains.
// Assumes the same timing parameters as the controller.
module psram_ctrl_checks
    import psram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned CLK_PERIOD_NS = 4,
    parameter int unsigned T_CE_NS       = 80,
    parameter int unsigned T_WP_NS       = 60,
    parameter int unsigned T_CP_NS       = 20,
    parameter int unsigned T_RD_MAX_NS   = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_wr_n,
    input logic              mem_rd_n,
    input logic              mem_blo_n,
    input logic              mem_bhi_n,
    input logic              mem_d_drive
);

    localparam int unsigned N_CE    = ns_to_cyc(T_CE_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WP    = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_CP    = ns_to_cyc(T_CP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_RDMAX = T_RD_MAX_NS / CLK_PERIOD_NS;
    localparam int unsigned KW      = 16;

    logic [KW-1:0] cs_hi_cnt;
    logic [KW-1:0] cs_lo_cnt;
    logic [KW-1:0] wr_lo_cnt;
    logic [KW-1:0] rd_lo_cnt;
    logic          had_access;

    // Saturating run-length counters for each strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_hi_cnt  <= '0;
            cs_lo_cnt  <= '0;
            wr_lo_cnt  <= '0;
            rd_lo_cnt  <= '0;
            had_access <= 1'b0;
        end else begin
            cs_hi_cnt  <= mem_cs_n  ? ((&cs_hi_cnt) ? cs_hi_cnt : cs_hi_cnt + 1'b1) : '0;
            cs_lo_cnt  <= !mem_cs_n ? ((&cs_lo_cnt) ? cs_lo_cnt : cs_lo_cnt + 1'b1) : '0;
            wr_lo_cnt  <= !mem_wr_n ? ((&wr_lo_cnt) ? wr_lo_cnt : wr_lo_cnt + 1'b1) : '0;
            rd_lo_cnt  <= !mem_rd_n ? ((&rd_lo_cnt) ? rd_lo_cnt : rd_lo_cnt + 1'b1) : '0;
            if (!mem_cs_n) had_access <= 1'b1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_cs_n && mem_wr_n && mem_rd_n && !mem_d_drive));

    assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (!mem_cs_n && mem_wr_n && !mem_blo_n && !mem_bhi_n));

    assert_read_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rvalid) |-> (cs_lo_cnt >= KW'(N_CE)));

    assert_rvalid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    assert_write_rd_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> mem_rd_n);

    assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> (wr_lo_cnt >= KW'(N_WP)));

    assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n) |-> mem_d_drive);

    assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_drive |-> mem_rd_n);

    assert_cs_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cs_n) && had_access) |-> (cs_hi_cnt >= KW'(N_CP)));

    assert_busy_on_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> !host_ready);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

    assert_rd_low_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_cnt <= KW'(N_RDMAX));

endmodule

bind psram_ctrl psram_ctrl_checks #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_CE_NS       (T_CE_NS),
    .T_WP_NS       (T_WP_NS),
    .T_CP_NS       (T_CP_NS)
) u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_wr_n    (mem_wr_n),
    .mem_rd_n    (mem_rd_n),
    .mem_blo_n   (mem_blo_n),
    .mem_bhi_n   (mem_bhi_n),
    .mem_d_drive (mem_d_drive)
);

// File: tb/psram_ctrl_test.sv
`timescale 1ns/1ps
module psram_ctrl_test;

    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;
    localparam int T     = 4;

    function automatic int cyc(input int ns);
        return (ns + T - 1) / T;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int L_RD   = cyc(80);
    localparam int L_WR   = mx(cyc(60), cyc(20));
    localparam int Q_RD   = mx(cyc(20), cyc(90) - L_RD);
    localparam int Q_WR   = mx(mx(cyc(15), cyc(20)), cyc(90) - L_WR);
    localparam int BUSY_RD = 1 + L_RD + Q_RD;
    localparam int BUSY_WR = 1 + L_WR + Q_WR;
    localparam int POKE_A  = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0;
    logic          host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [15:0]   host_wdata = '0;
    logic [1:0]    host_be = '0;
    logic          host_ready;
    logic [15:0]   host_rdata;
    logic          host_rvalid;
    logic [AW-1:0] mem_addr;
    logic          mem_cs_n, mem_pwr_en, mem_wr_n, mem_rd_n, mem_blo_n, mem_bhi_n;
    logic [15:0]   mem_d_out;
    logic          mem_d_drive;
    logic [15:0]   mem_d_in;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [15:0] model [WORDS];
    logic [15:0] expv  [WORDS];
    logic [15:0] cur_wdata = '0;

    always #2 clk = ~clk;

    psram_ctrl #(.ADDR_W(AW), .CLK_PERIOD_NS(T)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_be(host_be),
        .host_ready(host_ready), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_pwr_en(mem_pwr_en),
        .mem_wr_n(mem_wr_n), .mem_rd_n(mem_rd_n), .mem_blo_n(mem_blo_n),
        .mem_bhi_n(mem_bhi_n), .mem_d_out(mem_d_out), .mem_d_drive(mem_d_drive),
        .mem_d_in(mem_d_in)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp_v);
        end
    endtask

    // Memory model: a poison word unless a proper read is in progress.
    always @* begin
        if (!mem_cs_n && !mem_rd_n && mem_wr_n) mem_d_in = model[mem_addr];
        else                                    mem_d_in = 16'hBAD0;
    end

    // Memory model write: lanes and data sampled during the strobe, committed when it ends.
    bit            pend = 0;
    logic [AW-1:0] p_addr;
    logic [15:0]   p_data;
    logic          p_lo, p_hi;
    always @(negedge clk) begin
        if (!mem_cs_n && !mem_wr_n) begin
            pend = 1; p_addr = mem_addr; p_data = mem_d_drive ? mem_d_out : 16'h5A5A;
            p_lo = !mem_blo_n; p_hi = !mem_bhi_n;
        end else if (pend) begin
            if (p_lo) model[p_addr][7:0]  = p_data[7:0];
            if (p_hi) model[p_addr][15:8] = p_data[15:8];
            pend = 0;
        end
    end

    // Pin timing monitor, sampled away from the active edge.
    int cs_lo = 0, cs_hi = 0, since_fall = 0;
    bit seen_fall = 0, in_read = 0, rel_pend = 0;
    int wr_lo = 0, drv_cnt = 0, rd_lo = 0, rd_lo_max = 0, contention = 0, addr_moves = 0;
    logic [AW-1:0] addr_at_fall;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n) begin
                if (cs_lo == 0) begin
                    if (seen_fall) begin
                        check(cs_hi * T >= 20, "R5", "deselect gap ns", cs_hi * T, 20);
                        check(since_fall * T >= 90, "R5", "select-to-select ns", since_fall * T, 90);
                    end
                    if (!mem_wr_n) check(mem_rd_n == 1'b1, "R3", "read strobe at write start", mem_rd_n, 1);
                    seen_fall = 1; since_fall = 0; addr_at_fall = mem_addr; in_read = !mem_rd_n;
                end else if (mem_addr != addr_at_fall) begin
                    addr_moves++;
                end
                cs_lo++; cs_hi = 0;
            end else begin
                if (cs_lo != 0) begin
                    if (in_read) check(cs_lo == L_RD, "R2", "read strobe cycles", cs_lo, L_RD);
                    else         check(cs_lo == L_WR, "R3", "write strobe cycles", cs_lo, L_WR);
                end
                cs_lo = 0; cs_hi++;
            end
            since_fall++;
            if (!mem_wr_n) begin
                wr_lo++;
                if (mem_d_drive) drv_cnt++;
            end else if (wr_lo != 0) begin
                check(mem_d_drive == 1'b1, "R4", "data held after strobe", mem_d_drive, 1);
                check(drv_cnt * T >= 20, "R4", "data setup ns", drv_cnt * T, 20);
                check(mem_d_out == cur_wdata, "R4", "driven data", mem_d_out, cur_wdata);
                rel_pend = 1; wr_lo = 0; drv_cnt = 0;
            end else if (rel_pend) begin
                check(mem_d_drive == 1'b0, "R4", "bus released", mem_d_drive, 0);
                rel_pend = 0;
            end
            if (mem_d_drive && !mem_rd_n) contention++;
            if (!mem_rd_n) begin
                rd_lo++;
                if (rd_lo > rd_lo_max) rd_lo_max = rd_lo;
            end else begin
                rd_lo = 0;
            end
        end
    end

    // One host access; call at a negedge with host_ready high.
    task automatic access(input bit we, input int a, input logic [15:0] d,
                          input logic [1:0] be, input bit poke,
                          output int busy, output int nval, output logic [15:0] rd);
        host_req = 1; host_we = we; host_addr = AW'(a); host_wdata = d; host_be = be;
        if (we) cur_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 0; busy = 0; nval = 0; rd = '0;
        while (!host_ready && busy < 1000) begin
            busy++;
            if (host_rvalid) begin nval++; rd = host_rdata; end
            if (poke && busy == 3) begin
                host_req = 1; host_we = 1; host_addr = AW'(POKE_A);
                host_wdata = 16'hFFFF; host_be = 2'b11;
            end
            if (poke && busy == 6) host_req = 0;
            @(negedge clk);
        end
        host_req = 0;
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be);
        int b, n;
        logic [15:0] r;
        access(1'b1, a, d, be, 1'b0, b, n, r);
        check(b == BUSY_WR, "R6", "write busy cycles", b, BUSY_WR);
        check(n == 0, "R2", "no valid on write", n, 0);
        if (be[0]) expv[a][7:0]  = d[7:0];
        if (be[1]) expv[a][15:8] = d[15:8];
    endtask

    task automatic do_read(input int a, input bit poke, input string tag);
        int b, n;
        logic [15:0] r;
        access(1'b0, a, 16'h0, 2'b00, poke, b, n, r);
        check(b == BUSY_RD, "R6", "read busy cycles", b, BUSY_RD);
        check(n == 1, "R2", "valid pulses per read", n, 1);
        check(r == expv[a], tag, "read word", r, expv[a]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin model[i] = 16'h0; expv[i] = 16'h0; end
        repeat (3) @(negedge clk);
        check(mem_cs_n && mem_wr_n && mem_rd_n && mem_blo_n && mem_bhi_n, "R1",
              "strobes in reset", {mem_cs_n, mem_wr_n, mem_rd_n, mem_blo_n, mem_bhi_n}, 5'h1f);
        check(!mem_d_drive && mem_pwr_en, "R1", "bus/enable in reset", {mem_d_drive, mem_pwr_en}, 2'b01);
        rst_n = 1'b1;
        @(negedge clk);
        check(host_ready && !host_rvalid, "R1", "host side after reset", {host_ready, host_rvalid}, 2'b10);
        check(mem_cs_n && mem_rd_n && !mem_d_drive, "R1", "idle pins after reset",
              {mem_cs_n, mem_rd_n, mem_d_drive}, 3'b110);

        // R2/R3: full-word sweep, then read back every word.
        for (int a = 0; a < WORDS; a++) do_write(a, 16'(a * 16'h1111) ^ 16'hA5C3, 2'b11);
        for (int a = 0; a < WORDS; a++) do_read(a, 1'b0, "R2");

        // R3: lane patch sweep (low only, high only, neither), then read back.
        for (int a = 0; a < WORDS; a++) begin
            case (a % 4)
                0:       do_write(a, {8'hEE, 8'(a * 7)}, 2'b01);
                1:       do_write(a, {8'(a * 13), 8'h11}, 2'b10);
                2:       do_write(a, 16'h3C00 | 16'(a), 2'b11);
                default: do_write(a, 16'hFFFF, 2'b00);
            endcase
        end
        for (int a = 0; a < WORDS; a++) do_read(a, 1'b0, "R3");

        // R8: a request during a busy read is ignored.
        do_read(5, 1'b1, "R8");
        do_read(POKE_A, 1'b0, "R8");

        // Alternating write/read on one word.
        do_write(3, 16'h1234, 2'b11);
        do_read(3, 1'b0, "R2");
        do_write(3, 16'hABCD, 2'b10);
        do_read(3, 1'b0, "R3");

        repeat (4) @(negedge clk);
        check(contention == 0, "R4", "drive while read strobe", contention, 0);
        check(addr_moves == 0, "R7", "address moves under select", addr_moves, 0);
        check(rd_lo_max * T <= 1000, "R9", "longest read strobe ns", rd_lo_max * T, 1000);
        check(host_ready && mem_cs_n, "R1", "idle at end", {host_ready, mem_cs_n}, 2'b11);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule